// File: doc/BRIEF.md
# Privilege Mode and Exception-Return Control

This unit is the system-control register slice of a MIPS-style core. It keeps the 32-bit processor status word, a cycle counter, the saved exception PC and the saved error PC. From the status word it derives whether the core is in privileged (kernel) or unprivileged (user) mode. It also carries out three control commands: return from exception, interrupt enable and interrupt disable. Each command arrives as a one-cycle strobe with a 2-bit code.

The core reaches the registers through a 5-bit register number with separate read and write strobes. Reads are combinational. On a return from exception the unit issues a one-cycle redirect pulse with the target PC. A separate output gives the coprocessor branch condition. It is computed from two 10-bit vectors, the per-channel DMA completion flags and the per-channel enables. The condition is true when every enabled channel has finished.

Top module: `sysctl_unit`

## Requirements
- R1: `kernel_mode` is 1 when status bit 1 (exception level) or status bit 2 (error level) is set, or when the privilege field in status bits 4:3 is 00. Otherwise it is 0. It follows the stored status word in the same cycle.
- R2: With `cmd_valid`=1 and `cmd_op`=2'b01 (exception return):
  - If status bit 2 is set, the target is register 30 (error PC) and bit 2 is cleared.
  - Otherwise the target is register 14 (exception PC) and bit 1 is cleared.
  - `redirect_valid` is high for exactly the one cycle after the command edge, and `redirect_pc` then holds the target.
- R3: `cmd_op`=2'b10 (enable) sets status bit 16, and `cmd_op`=2'b11 (disable) clears it. Either command acts only when at least one of these holds: bit 17 is set, bit 1 is set, bit 2 is set, or bits 4:3 are 00. Otherwise the status word is unchanged.
- R4: A read of register 12 returns the status word ANDed with 0xF0C79C1F.
- R5: Register 9 increments by one on every clock and wraps from 0xFFFFFFFF to 0. A write loads the written value, and counting resumes from it on the next clock.
- R6: `branch_cond` is 1 exactly when (`dma_stat` & `dma_en`) == `dma_en`. In particular it is 1 when `dma_en` is zero.
- R7: Every register other than 9 and 12 reads back exactly the last value written to it.
- R8: After reset the following hold:
  - The status word is 0x00000004, so the core is in kernel mode.
  - The counter, the exception PC and the error PC are zero.
  - `redirect_valid` is 0.
- R9: When a register write and a command fall in the same cycle, the command is decided on the pre-edge state:
  - A status write overrides the command's status update.
  - The redirect target is chosen from the status word and PCs as they stood before that edge.
- R10: `reg_rdata` is zero while `reg_rd` is low.

Ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register number |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data (combinational) |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 01 return, 10 enable, 11 disable |
| dma_stat | input | 10 | Per-channel completion flags |
| dma_en | input | 10 | Per-channel condition enables |
| branch_cond | output | 1 | Coprocessor branch condition |
| kernel_mode | output | 1 | Privileged mode indicator |
| redirect_valid | output | 1 | One-cycle PC redirect pulse |
| redirect_pc | output | 32 | Redirect target |

## Verification
A register write and a command can land on the same clock edge. This happens when software rewrites the status word or an exception PC while a return is in flight. The bench provokes this in two ways: it drives an exception return in the same cycle as a status write, and again in the same cycle as an exception-PC write. It then judges two things. First, the redirect target must come from the pre-edge values. Second, the status read-back and the mode output must show the written value, not the command's update. A counter write that lands on a counting edge is also checked: the written value must be loaded rather than incremented.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  localparam int BIT_EXL = 1;
  localparam int BIT_ERL = 2;
  localparam int PRIV_LO = 3;
  localparam int PRIV_HI = 4;
  localparam int BIT_IE  = 16;
  localparam int BIT_EDI = 17;

  localparam int IDX_COUNT  = 9;
  localparam int IDX_STATUS = 12;
  localparam int IDX_EPC    = 14;
  localparam int IDX_ERRPC  = 30;

  localparam logic [DATA_W-1:0] STATUS_READ_MASK = 32'hF0C7_9C1F;
  localparam logic [DATA_W-1:0] STATUS_RESET     = 32'h0000_0004;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_RET  = 2'b01,
    OP_IEN  = 2'b10,
    OP_IDIS = 2'b11
  } ctl_op_e;

  function automatic logic priv_kernel(input logic [DATA_W-1:0] st);
    return st[BIT_EXL] | st[BIT_ERL] | (st[PRIV_HI:PRIV_LO] == 2'b00);
  endfunction

  function automatic logic ie_change_ok(input logic [DATA_W-1:0] st);
    return st[BIT_EDI] | priv_kernel(st);
  endfunction

endpackage

// File: rtl/sysctl_status.sv
module sysctl_status
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] status_q,
  output logic              ret_fire,
  output logic              ret_to_err
);

  logic [DATA_W-1:0] status_d;
  logic              ie_ok;

  assign ie_ok      = ie_change_ok(status_q);
  assign ret_fire   = cmd_valid && (cmd_op == OP_RET);
  assign ret_to_err = status_q[BIT_ERL];

  always_comb begin
    status_d = status_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_RET: begin
          if (status_q[BIT_ERL]) status_d[BIT_ERL] = 1'b0;
          else                   status_d[BIT_EXL] = 1'b0;
        end
        OP_IEN:  if (ie_ok) status_d[BIT_IE] = 1'b1;
        OP_IDIS: if (ie_ok) status_d[BIT_IE] = 1'b0;
        default: ;
      endcase
    end
    if (wr_en) status_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STATUS_RESET;
    else        status_q <= status_d;
  end

endmodule

// File: rtl/sysctl_count.sv
module sysctl_count
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] count_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (load) count_q <= load_val;
    else           count_q <= count_q + 1'b1;
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] epc_q,
  output logic [DATA_W-1:0] errpc_q
);

  localparam int NREG = 1 << ADDR_W;

  logic [NREG-1:0][DATA_W-1:0] bank_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_COUNT || i == IDX_STATUS) begin : g_hole
      assign bank_q[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank_q[i] <= '0;
        else if (wr_en && (wr_addr == ADDR_W'(i)))
          bank_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = bank_q[rd_addr];
  assign epc_q   = bank_q[IDX_EPC];
  assign errpc_q = bank_q[IDX_ERRPC];

endmodule

// File: rtl/sysctl_redirect.sv
module sysctl_redirect
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_fire,
  input  logic              ret_to_err,
  input  logic [DATA_W-1:0] epc,
  input  logic [DATA_W-1:0] errpc,
  output logic              redirect_valid,
  output logic [DATA_W-1:0] redirect_pc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= ret_fire;
      if (ret_fire) redirect_pc <= ret_to_err ? errpc : epc;
    end
  end

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CHAN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CHAN_W-1:0] dma_stat,
  input  logic [CHAN_W-1:0] dma_en,
  output logic              branch_cond,
  output logic              kernel_mode,
  output logic              redirect_valid,
  output logic [31:0]       redirect_pc
);

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] epc_q;
  logic [DATA_W-1:0] errpc_q;
  logic              wr_status;
  logic              wr_count;
  logic              ret_fire;
  logic              ret_to_err;

  assign wr_status = reg_wr && (reg_addr == ADDR_W'(IDX_STATUS));
  assign wr_count  = reg_wr && (reg_addr == ADDR_W'(IDX_COUNT));

  sysctl_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_status),
    .wr_data    (reg_wdata),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .status_q   (status_q),
    .ret_fire   (ret_fire),
    .ret_to_err (ret_to_err)
  );

  sysctl_count u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_count),
    .load_val (reg_wdata),
    .count_q  (count_q)
  );

  sysctl_regbank #(.ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .rd_addr (reg_addr),
    .rd_data (bank_rd),
    .epc_q   (epc_q),
    .errpc_q (errpc_q)
  );

  sysctl_redirect u_redir (
    .clk            (clk),
    .rst_n          (rst_n),
    .ret_fire       (ret_fire),
    .ret_to_err     (ret_to_err),
    .epc            (epc_q),
    .errpc          (errpc_q),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_W'(IDX_STATUS))     reg_rdata = status_q & STATUS_READ_MASK;
      else if (reg_addr == ADDR_W'(IDX_COUNT)) reg_rdata = count_q;
      else                                     reg_rdata = bank_rd;
    end
  end

  assign kernel_mode = priv_kernel(status_q);
  assign branch_cond = ((dma_stat & dma_en) == dma_en);

endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CHAN_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [31:0]       reg_rdata,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [CHAN_W-1:0] dma_en,
  input logic              branch_cond,
  input logic              kernel_mode,
  input logic              redirect_valid,
  input logic [31:0]       status_q,
  input logic [31:0]       count_q
);

  logic st_wr;
  logic cnt_wr;
  logic is_ret;
  logic is_ie;
  logic locked;

  assign st_wr  = reg_wr && (reg_addr == ADDR_W'(IDX_STATUS));
  assign cnt_wr = reg_wr && (reg_addr == ADDR_W'(IDX_COUNT));
  assign is_ret = cmd_valid && (cmd_op == 2'b01);
  assign is_ie  = cmd_valid && cmd_op[1];
  assign locked = !status_q[17] && !status_q[1] && !status_q[2] && (status_q[4:3] != 2'b00);

  AST_KERNEL_ON_ERL: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[2] |-> kernel_mode); // R1

  AST_REDIRECT_FROM_RET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(is_ret)); // R2

  AST_RET_DROPS_ERL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ret && status_q[2] && !st_wr) |=> !status_q[2]); // R2

  AST_IE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ie && locked && !st_wr) |=> $stable(status_q)); // R3

  AST_STATUS_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(IDX_STATUS)) |-> ((reg_rdata & ~STATUS_READ_MASK) == 32'h0)); // R4

  AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count_q == $past(count_q) + 32'd1)); // R5

  AST_BRANCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en == '0) |-> branch_cond); // R6

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == 32'h0)); // R10

endmodule

bind sysctl_unit sysctl_unit_chk #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_addr       (reg_addr),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .reg_rdata      (reg_rdata),
  .cmd_valid      (cmd_valid),
  .cmd_op         (cmd_op),
  .dma_en         (dma_en),
  .branch_cond    (branch_cond),
  .kernel_mode    (kernel_mode),
  .redirect_valid (redirect_valid),
  .status_q       (status_q),
  .count_q        (count_q)
);

// File: tb/sim_sysctl_unit.sv
module sim_sysctl_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [9:0]  dma_stat = '0;
  logic [9:0]  dma_en = '0;
  logic        branch_cond;
  logic        kernel_mode;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .dma_stat(dma_stat),
    .dma_en(dma_en), .branch_cond(branch_cond), .kernel_mode(kernel_mode),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic exp_kernel(input logic [31:0] s);
    return (s[4:3] == 2'd0) || (s[2:1] != 2'd0);
  endfunction

  task automatic write_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    read_reg(5'd12, v); check("R8 status", v, 32'h4);
    check("R8 kernel", {31'b0, kernel_mode}, 32'h1);
    check("R8 redirect", {31'b0, redirect_valid}, 32'h0);
    read_reg(5'd14, v); check("R8 epc", v, 32'h0);
    read_reg(5'd30, v); check("R8 errpc", v, 32'h0);
    check("R10 idle rdata", reg_rdata, 32'h0);
  endtask

  task automatic t_mode();
    logic [31:0] pats [6] = '{32'h18, 32'h08, 32'h10, 32'h00, 32'h0A, 32'h0C};
    foreach (pats[i]) begin
      write_reg(5'd12, pats[i]);
      check("R1 mode", {31'b0, kernel_mode}, {31'b0, exp_kernel(pats[i])});
    end
  endtask

  task automatic t_status_mask();
    logic [31:0] v;
    write_reg(5'd12, 32'hFFFF_FFFF);
    read_reg(5'd12, v); check("R4 masked read", v, 32'hF0C7_9C1F);
    write_reg(5'd12, 32'h0F38_63E0);
    read_reg(5'd12, v); check("R4 masked zero", v, 32'h0);
  endtask

  task automatic t_return();
    logic [31:0] v;
    write_reg(5'd14, 32'h0000_1000);
    write_reg(5'd30, 32'h0000_2000);
    write_reg(5'd12, 32'h0000_001E);
    send_cmd(2'b01);
    check("R2 pulse err", {31'b0, redirect_valid}, 32'h1);
    check("R2 target err", redirect_pc, 32'h2000);
    read_reg(5'd12, v); check("R2 erl cleared", v, 32'h1A);
    @(negedge clk);
    check("R2 pulse width", {31'b0, redirect_valid}, 32'h0);
    send_cmd(2'b01);
    check("R2 target epc", redirect_pc, 32'h1000);
    read_reg(5'd12, v); check("R2 exl cleared", v, 32'h18);
    check("R1 user after return", {31'b0, kernel_mode}, 32'h0);
  endtask

  task automatic t_ie();
    logic [31:0] v;
    write_reg(5'd12, 32'h0000_0018);
    send_cmd(2'b10);
    read_reg(5'd12, v); check("R3 enable locked", v, 32'h18);
    check("R3 no redirect", {31'b0, redirect_valid}, 32'h0);
    write_reg(5'd12, 32'h0001_0018);
    send_cmd(2'b11);
    read_reg(5'd12, v); check("R3 disable locked", v, 32'h1_0018);
    write_reg(5'd12, 32'h0002_0018);
    send_cmd(2'b10);
    read_reg(5'd12, v); check("R3 enable via edi", v, 32'h3_0018);
    send_cmd(2'b11);
    read_reg(5'd12, v); check("R3 disable via edi", v, 32'h2_0018);
    write_reg(5'd12, 32'h0000_0000);
    send_cmd(2'b10);
    read_reg(5'd12, v); check("R3 enable kernel", v, 32'h1_0000);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    @(negedge clk);
    read_reg(5'd9, a);
    @(negedge clk);
    read_reg(5'd9, b); check("R5 advance", b, a + 32'd1);
    write_reg(5'd9, 32'hFFFF_FFFE);
    read_reg(5'd9, a); check("R5 load", a, 32'hFFFF_FFFE);
    @(negedge clk);
    read_reg(5'd9, a); check("R5 after load", a, 32'hFFFF_FFFF);
    @(negedge clk);
    read_reg(5'd9, a); check("R5 wrap", a, 32'h0);
  endtask

  task automatic t_branch();
    logic [9:0] st [5] = '{10'h000, 10'h3FF, 10'h3FE, 10'h2A5, 10'h1FF};
    logic [9:0] en [5] = '{10'h000, 10'h3FF, 10'h3FF, 10'h005, 10'h200};
    logic       ex [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    foreach (st[i]) begin
      @(negedge clk);
      dma_stat = st[i]; dma_en = en[i];
      #1;
      check("R6 branch", {31'b0, branch_cond}, {31'b0, ex[i]});
    end
  endtask

  task automatic t_other();
    logic [31:0] v;
    write_reg(5'd3, 32'hDEAD_BEEF);
    write_reg(5'd31, 32'h1234_5678);
    read_reg(5'd3, v);  check("R7 reg3", v, 32'hDEAD_BEEF);
    read_reg(5'd31, v); check("R7 reg31", v, 32'h1234_5678);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    write_reg(5'd14, 32'h0000_0100);
    write_reg(5'd30, 32'h0000_0300);
    write_reg(5'd12, 32'h0000_0006);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01;
    reg_wr = 1'b1; reg_addr = 5'd12; reg_wdata = 32'h0000_0018;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; reg_wr = 1'b0;
    check("R9 target pre-edge", redirect_pc, 32'h300);
    read_reg(5'd12, v); check("R9 write wins", v, 32'h18);
    check("R9 mode from write", {31'b0, kernel_mode}, 32'h0);
    write_reg(5'd12, 32'h0000_0002);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01;
    reg_wr = 1'b1; reg_addr = 5'd14; reg_wdata = 32'h0000_0200;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00; reg_wr = 1'b0;
    check("R9 old epc used", redirect_pc, 32'h100);
    read_reg(5'd14, v); check("R9 epc written", v, 32'h200);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_status_mask();
    t_return();
    t_ie();
    t_count();
    t_branch();
    t_other();
    t_collide();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule